// File: doc/BRIEF.md
# Microcode Sequencer Micro-op Emitter

This block delivers micro-operations for instructions whose expansion is too long for the hardware decoders. The decode stage hands it a start request that carries the entry address of a sequence in an internal ROM and the total number of micro-ops in that sequence. If the count exceeds the lane count, the block accepts the request and takes over micro-op delivery. It then streams the sequence out of the ROM as beats of up to four micro-ops. Each beat appears on a four-lane output, and every lane has its own valid bit.

While a sequence is running, the block holds the normal decoders in a stall. A downstream ready input can pause each beat without losing or repeating micro-ops. When the final beat is accepted, the stall drops in the next cycle and a new request can be taken in that same cycle, so decoding resumes without a gap. The ROM holds a computed table of example sequences.

Top module: `ucs_emitter`

## Requirements
- R1: While rst_ni is low, and after it is released, the block is idle: start_ready_o=1, dec_stall_o=0, out_valid_o=0, lane_valid_o=0.
- R2: A start request whose count is LANES (4) or fewer is ignored. out_valid_o and dec_stall_o stay 0 and start_ready_o stays 1.
- R3: A start request whose count exceeds 4 is accepted on the clock edge where start_valid_i and start_ready_o are both high. In the next cycle, out_valid_o=1 and dec_stall_o=1.
- R4: Lane k of beat b carries ROM[(entry+4*b+k) mod 64]. ROM word at address a is ((a*0x9E37) xor 0x5A5A) mod 2^16. Lane k occupies uop_o[16k+15:16k].
- R5: Every beat except the final one has all four lanes valid. The final beat has its lowest (count-4*b) lanes valid, its remaining lanes invalid with zero data, and last_o=1. last_o is 0 on every other beat.
- R6: While out_valid_o=1 and out_ready_i=0, the outputs hold their values into the next cycle, so no micro-op is lost or repeated.
- R7: dec_stall_o stays 1 from the cycle after acceptance until the final beat is accepted. It is 0 in the cycle right after that acceptance, and a new start can be accepted in that same cycle.
- R8: While a sequence is active, start_ready_o=0, and a start request has no effect on the running sequence.
- R9: A sequence of count n is delivered in exactly ceil(n/4) beats, carrying n valid micro-ops in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_valid_i | input | 1 | Start request from decode |
| start_ready_o | output | 1 | Block can take a start request |
| start_entry_i | input | 6 | ROM entry address of the sequence |
| start_count_i | input | 6 | Total micro-op count of the sequence |
| dec_stall_o | output | 1 | Holds the normal decoders disabled |
| out_valid_o | output | 1 | A beat is presented |
| out_ready_i | input | 1 | Downstream accepts the beat |
| uop_o | output | 64 | Four 16-bit micro-op lanes |
| lane_valid_o | output | 4 | Per-lane valid bits |
| last_o | output | 1 | Final beat of the sequence |

## Verification
All beat outputs are decoded combinationally from registered state. The first beat is therefore due one clock after the accepting edge, and each later beat one clock after the previous beat is accepted. The stall release and the restored start_ready_o are due one clock after the final accept. The bench drives its inputs on the falling edge and samples all outputs on the next falling edge. At that point exactly one rising edge has passed, so every check reads the state that this edge produced. Under backpressure, the bench compares each sampled beat against the beat it has not yet seen accepted, which also checks that the beat is held steady.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

  // example sequence table, computed per address
  function automatic logic [31:0] rom_word(input logic [31:0] addr);
    return (addr * 32'h9E37) ^ 32'h5A5A;
  endfunction
endpackage

// File: rtl/ucs_step.sv
module ucs_step
  import ucs_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_valid_i,
  input  logic [ADDR_W-1:0] start_entry_i,
  input  logic [CNT_W-1:0]  start_count_i,
  input  logic              beat_take_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [CNT_W-1:0]  remain_o
);
  localparam logic [CNT_W-1:0]  LanesC  = CNT_W'(LANES);
  localparam logic [ADDR_W-1:0] StrideA = ADDR_W'(LANES);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  remain_q;
  logic              long_req;
  logic              final_beat;

  assign long_req   = start_count_i > LanesC;
  assign final_beat = remain_q <= LanesC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      base_q   <= '0;
      remain_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_valid_i && long_req) begin
            state_q  <= ST_RUN;
            base_q   <= start_entry_i;
            remain_q <= start_count_i;
          end
        end
        ST_RUN: begin
          if (beat_take_i) begin
            if (final_beat) begin
              state_q  <= ST_IDLE;
              remain_q <= '0;
            end else begin
              base_q   <= base_q + StrideA;
              remain_q <= remain_q - LanesC;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q == ST_RUN);
  assign base_o   = base_q;
  assign remain_o = remain_q;
endmodule

// File: rtl/ucs_rom.sv
module ucs_rom
  import ucs_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 6,
  parameter int UOP_W  = 16
) (
  input  logic [ADDR_W-1:0]      base_i,
  output logic [LANES*UOP_W-1:0] data_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_port
    logic [ADDR_W-1:0] addr;
    logic [31:0]       word;
    assign addr = base_i + ADDR_W'(k);  // wraps at table end
    assign word = rom_word(32'(addr));
    assign data_o[k*UOP_W +: UOP_W] = word[UOP_W-1:0];
  end
endmodule

// File: rtl/ucs_lane_pack.sv
module ucs_lane_pack #(
  parameter int LANES = 4,
  parameter int UOP_W = 16,
  parameter int CNT_W = 6
) (
  input  logic                   busy_i,
  input  logic [CNT_W-1:0]       remain_i,
  input  logic [LANES*UOP_W-1:0] raw_i,
  output logic [LANES*UOP_W-1:0] uop_o,
  output logic [LANES-1:0]       lane_valid_o,
  output logic                   last_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic live;
    assign live = busy_i && (CNT_W'(k) < remain_i);
    assign lane_valid_o[k] = live;
    assign uop_o[k*UOP_W +: UOP_W] = live ? raw_i[k*UOP_W +: UOP_W] : '0;
  end
  assign last_o = busy_i && (remain_i <= CNT_W'(LANES));
endmodule

// File: rtl/ucs_emitter.sv
module ucs_emitter #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 6,
  parameter int UOP_W  = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_valid_i,
  output logic                   start_ready_o,
  input  logic [ADDR_W-1:0]      start_entry_i,
  input  logic [CNT_W-1:0]       start_count_i,
  output logic                   dec_stall_o,
  output logic                   out_valid_o,
  input  logic                   out_ready_i,
  output logic [LANES*UOP_W-1:0] uop_o,
  output logic [LANES-1:0]       lane_valid_o,
  output logic                   last_o
);
  logic              busy;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  remain;
  logic [LANES*UOP_W-1:0] raw;

  ucs_step #(.LANES(LANES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_step (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_valid_i (start_valid_i),
    .start_entry_i (start_entry_i),
    .start_count_i (start_count_i),
    .beat_take_i   (busy && out_ready_i),
    .busy_o        (busy),
    .base_o        (base),
    .remain_o      (remain)
  );

  ucs_rom #(.LANES(LANES), .ADDR_W(ADDR_W), .UOP_W(UOP_W)) u_rom (
    .base_i (base),
    .data_o (raw)
  );

  ucs_lane_pack #(.LANES(LANES), .UOP_W(UOP_W), .CNT_W(CNT_W)) u_pack (
    .busy_i       (busy),
    .remain_i     (remain),
    .raw_i        (raw),
    .uop_o        (uop_o),
    .lane_valid_o (lane_valid_o),
    .last_o       (last_o)
  );

  assign out_valid_o   = busy;
  assign dec_stall_o   = busy;
  assign start_ready_o = !busy;
endmodule

// File: rtl/ucs_checker.sv
module ucs_checker #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 6,
  parameter int UOP_W  = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_valid_i,
  input logic                   start_ready_o,
  input logic [CNT_W-1:0]       start_count_i,
  input logic                   dec_stall_o,
  input logic                   out_valid_o,
  input logic                   out_ready_i,
  input logic [LANES*UOP_W-1:0] uop_o,
  input logic [LANES-1:0]       lane_valid_o,
  input logic                   last_o
);
  logic short_take, long_take;
  assign short_take = start_valid_i && start_ready_o && (start_count_i <= CNT_W'(LANES));
  assign long_take  = start_valid_i && start_ready_o && (start_count_i >  CNT_W'(LANES));

  assert_short_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_take |=> (!dec_stall_o && !out_valid_o));

  assert_start_takes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_take |=> (out_valid_o && dec_stall_o));

  assert_full_beats_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !last_o) |-> (&lane_valid_o));

  assert_lanes_packed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((lane_valid_o != '0) &&
                     ((lane_valid_o & (lane_valid_o + LANES'(1))) == '0)));

  assert_hold_beat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(uop_o) && $stable(lane_valid_o) && $stable(last_o)));

  assert_stall_covers_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> dec_stall_o);

  assert_stall_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && last_o) |=> (!dec_stall_o && start_ready_o));

  assert_busy_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_stall_o |-> !start_ready_o);
endmodule

bind ucs_emitter ucs_checker #(
  .LANES(LANES), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .UOP_W(UOP_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_valid_i (start_valid_i),
  .start_ready_o (start_ready_o),
  .start_count_i (start_count_i),
  .dec_stall_o   (dec_stall_o),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .uop_o         (uop_o),
  .lane_valid_o  (lane_valid_o),
  .last_o        (last_o)
);

// File: tb/ucs_emitter_tb.sv
`timescale 1ns/1ps
module ucs_emitter_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start_valid_i;
  logic        start_ready_o;
  logic [5:0]  start_entry_i;
  logic [5:0]  start_count_i;
  logic        dec_stall_o;
  logic        out_valid_o;
  logic        out_ready_i;
  logic [63:0] uop_o;
  logic [3:0]  lane_valid_o;
  logic        last_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  ucs_emitter u_dut (
    .clk_i, .rst_ni, .start_valid_i, .start_ready_o, .start_entry_i,
    .start_count_i, .dec_stall_o, .out_valid_o, .out_ready_i, .uop_o,
    .lane_valid_o, .last_o
  );

  // {entry, count, ready pattern, expected beats}
  localparam logic [24:0] VEC [8] = '{
    {6'd0,  6'd5,  8'hFF, 5'd2},
    {6'd10, 6'd8,  8'hFF, 5'd2},
    {6'd20, 6'd9,  8'hAA, 5'd3},
    {6'd60, 6'd7,  8'hFF, 5'd2},
    {6'd33, 6'd63, 8'hB6, 5'd16},
    {6'd1,  6'd12, 8'h80, 5'd3},
    {6'd40, 6'd17, 8'hFF, 5'd5},
    {6'd5,  6'd6,  8'h0F, 5'd2}
  };

  function automatic logic [15:0] exp_rom(input int a);
    logic [31:0] t;
    t = (32'(a) * 32'h9E37) ^ 32'h5A5A;
    return t[15:0];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, "start_ready", 64'(start_ready_o), 64'd1);
    chk(req, "dec_stall",   64'(dec_stall_o),   64'd0);
    chk(req, "out_valid",   64'(out_valid_o),   64'd0);
    chk(req, "lane_valid",  64'(lane_valid_o),  64'd0);
  endtask

  // call at a negedge; returns at the negedge after the final accept
  task automatic run_seq(input int entry, input int count, input logic [7:0] rdy,
                         input int exp_beats, input bit poke);
    int b = 0;
    int cyc = 0;
    int lanes_seen = 0;
    int nb = (count + 3) / 4;
    chk("R3", "ready_at_start", 64'(start_ready_o), 64'd1);
    start_valid_i = 1'b1;
    start_entry_i = 6'(entry);
    start_count_i = 6'(count);
    @(negedge clk_i);
    start_valid_i = poke;  // R8: request while busy must not disturb
    start_entry_i = 6'(entry + 17);
    start_count_i = 6'd40;
    chk("R3", "valid_after_accept", 64'(out_valid_o), 64'd1);
    chk("R7", "stall_after_accept", 64'(dec_stall_o), 64'd1);
    while (b < nb && cyc < 400) begin
      logic r;
      logic [3:0]  ev;
      logic [63:0] ed;
      r = rdy[cyc % 8];
      ev = '0;
      ed = '0;
      for (int k = 0; k < 4; k++) begin
        if (4*b + k < count) begin
          ev[k] = 1'b1;
          ed[16*k +: 16] = exp_rom((entry + 4*b + k) % 64);
        end
      end
      chk("R4", $sformatf("uop beat %0d", b), uop_o, ed);
      chk("R5", $sformatf("lane_valid beat %0d", b), 64'(lane_valid_o), 64'(ev));
      chk("R5", $sformatf("last beat %0d", b), 64'(last_o), 64'(b == nb - 1));
      chk("R8", "ready_low_busy", 64'(start_ready_o), 64'd0);
      chk("R7", "stall_busy", 64'(dec_stall_o), 64'd1);
      out_ready_i = r;
      @(negedge clk_i);
      if (r) begin
        b++;
        lanes_seen += $countones(ev);
      end
      cyc++;
    end
    start_valid_i = 1'b0;
    out_ready_i = 1'b0;
    chk("R9", "beats", 64'(b), 64'(exp_beats));
    chk("R9", "lanes", 64'(lanes_seen), 64'(count));
    chk("R7", "stall_released", 64'(dec_stall_o), 64'd0);
    chk("R7", "ready_restored", 64'(start_ready_o), 64'd1);
    chk("R7", "no_extra_beat", 64'(out_valid_o), 64'd0);
  endtask

  task automatic short_req(input int count);
    start_valid_i = 1'b1;
    start_entry_i = 6'd3;
    start_count_i = 6'(count);
    @(negedge clk_i);
    start_valid_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk_idle("R2");
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    start_valid_i = 1'b0;
    start_entry_i = '0;
    start_count_i = '0;
    out_ready_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk_idle("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1");

    short_req(4);
    short_req(0);
    short_req(3);

    for (int i = 0; i < 8; i++) begin
      run_seq(int'(VEC[i][24:19]), int'(VEC[i][18:13]), VEC[i][12:5],
              int'(VEC[i][4:0]), i[0]);
    end

    // R7: back-to-back sequences, restart in the release cycle
    run_seq(2, 5, 8'hFF, 2, 1'b0);
    run_seq(50, 13, 8'hFF, 4, 1'b1);

    // R6: long hold on the first beat
    start_valid_i = 1'b1;
    start_entry_i = 6'd7;
    start_count_i = 6'd9;
    @(negedge clk_i);
    start_valid_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk("R6", "held_uop", uop_o,
          {exp_rom(10), exp_rom(9), exp_rom(8), exp_rom(7)});
      chk("R6", "held_valid", 64'(lane_valid_o), 64'hF);
      @(negedge clk_i);
    end

    // R1: reset in mid-sequence returns to idle
    rst_ni = 1'b0;
    #1;
    chk_idle("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule